// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Wake-up

This block receives asynchronous serial characters from a shared line and can work on a multidrop bus. A 2-bit mode input selects one of two framings. The first is an 8-bit character with an optional parity bit, which is checked for even or odd parity. The second is a 9-bit character whose ninth bit tells an address frame (1) from a data frame (0). The line is oversampled by a 16x baud tick that comes from outside the block. Each character that is accepted is presented as a byte, a ninth-bit flag, a status word and a one-cycle receive interrupt.

A slave station on a multidrop bus sets the wake-up enable while it waits to be addressed. In that state the block drops data frames without a trace and reports only address frames. After it recognises its own address, software clears the wake-up enable so that the data frames which follow are reported as well. Software reads a result and then pulses the read-acknowledge input. Errors can be found by masking the status word with 0x1C.

The receiver is one state machine with four named states. IDLE waits for a falling edge on the line. START counts to the middle of the start bit and either confirms it or returns to IDLE on a glitch. SHIFT samples each data, parity or ninth bit at its centre. STOP samples the stop bit and signals frame completion. The transitions are IDLE→START on a falling edge in a valid mode, START→SHIFT when the line is low at mid-bit, START→IDLE when it is high at mid-bit, SHIFT→STOP after the last data-phase bit, and STOP→IDLE at the stop-bit centre.

Top module: `mdrop_rx`

## Requirements
- R1: Mode 2'b10 receives a start bit, eight data bits sent least-significant first, and a stop bit. On completion it loads data_o, sets status_o[0] (data valid) and forces rb8_o to 0.
- R2: In mode 2'b10 with par_en_i=1, a parity bit follows the eight data bits. par_even_i=1 requires an even number of ones across the data and parity bits, and par_even_i=0 requires an odd number. A mismatch sets status_o[3].
- R3: In mode 2'b10 with par_en_i=0, the frame has no parity bit and status_o[3] is never set.
- R4: Mode 2'b11 receives nine data-phase bits and places the ninth in rb8_o. In this mode par_en_i has no effect and status_o[3] stays 0.
- R5: In mode 2'b11 with wake_en_i=1, a frame whose ninth bit is 0 is dropped. data_o, rb8_o and status_o keep their values and irq_o stays low. A frame whose ninth bit is 1 is loaded and interrupts.
- R6: In mode 2'b11 with wake_en_i=0, every frame is loaded and interrupts, whatever its ninth bit.
- R7: A stop bit sampled low sets status_o[2] (framing error) on the frame's result.
- R8: If a frame is accepted while status_o[0] is still set, status_o[4] (overrun) is set and data_o takes the newer character.
- R9: A one-cycle pulse on ack_i clears status_o[0], [2], [3] and [4]. data_o and rb8_o keep their values.
- R10: A start bit is taken only on a falling edge and only if the line is still low at sample 8 of 16. A shorter low pulse produces no frame. The control inputs are captured when the start bit is confirmed.
- R11: Mode values 2'b00 and 2'b01 receive nothing.
- R12: irq_o is a single-cycle pulse, raised in the same cycle that data_o, rb8_o and status_o take the accepted frame.
- R13: After reset, data_o, rb8_o, status_o and irq_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| mode_i | input | 2 | 10: 8-bit framing, 11: 9-bit framing, others: off |
| par_en_i | input | 1 | Parity bit present and checked (8-bit mode) |
| par_even_i | input | 1 | 1: even parity, 0: odd parity |
| wake_en_i | input | 1 | Report only address frames (9-bit mode) |
| ack_i | input | 1 | Read acknowledge; clears valid and error flags |
| data_o | output | 8 | Received character |
| rb8_o | output | 1 | Received ninth bit |
| status_o | output | 8 | [4] overrun, [3] parity error, [2] framing error, [0] valid |
| irq_o | output | 1 | Receive interrupt pulse |

## Verification
In 8-bit mode, bytes with alternating and clustered bit patterns are sent without parity. These show whether the bit order is least-significant first and whether any bits are dropped. Frames with correct and deliberately wrong parity are sent under both polarities, which separates even parity from odd. In 9-bit mode, address and data frames are interleaved with wake-up off and then on, which separates reporting every frame from filtering to address frames only. A low stop bit, two unacknowledged frames in a row, a short low glitch and a frame sent in a disabled mode each test one flag or one rejection path against the clean case.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_SHIFT,
        ST_STOP
    } rx_state_e;

    localparam logic [1:0] MODE_UART8 = 2'b10;
    localparam logic [1:0] MODE_UART9 = 2'b11;

    localparam int STAT_W     = 8;
    localparam int STAT_VALID = 0;
    localparam int STAT_FERR  = 2;
    localparam int STAT_PERR  = 3;
    localparam int STAT_OVR   = 4;

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_even;
        logic wake;
    } frame_cfg_t;

endpackage

// File: rtl/mdrop_rx_sync.sv
module mdrop_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic rx_o
);

    logic [STAGES-1:0] pipe_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= 1'b1;
                else        pipe_q <= rx_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '1;
                else        pipe_q <= {pipe_q[STAGES-2:0], rx_i};
            end
        end
    endgenerate

    assign rx_o = pipe_q[STAGES-1];

endmodule

// File: rtl/mdrop_rx_fsm.sv
module mdrop_rx_fsm
    import mdrop_rx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          rx_i,
    input  logic [1:0]    mode_i,
    input  logic          par_en_i,
    input  logic          par_even_i,
    input  logic          wake_en_i,
    output logic          done_o,
    output logic [DW:0]   bits_o,
    output logic          stop_o,
    output frame_cfg_t    cfg_o
);

    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(DW + 1);
    localparam logic [CW-1:0] MID_C  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);
    localparam logic [IW-1:0] IDX_LONG  = IW'(DW);
    localparam logic [IW-1:0] IDX_SHORT = IW'(DW - 1);

    rx_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [DW:0]   shreg_q;
    logic          rx_prev_q;
    logic          done_q;
    logic          stop_q;
    frame_cfg_t    cfg_q;

    logic          fall_c;
    logic          mid_c;
    logic          centre_c;
    logic [IW-1:0] last_idx_c;

    assign fall_c     = tick_i && rx_prev_q && !rx_i;
    assign mid_c      = tick_i && (cnt_q == MID_C);
    assign centre_c   = tick_i && (cnt_q == LAST_C);
    assign last_idx_c = (cfg_q.nine || cfg_q.par_en) ? IDX_LONG : IDX_SHORT;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (fall_c && mode_i[1])            state_d = ST_START;
            ST_START: if (mid_c)                          state_d = rx_i ? ST_IDLE : ST_SHIFT;
            ST_SHIFT: if (centre_c && idx_q == last_idx_c) state_d = ST_STOP;
            ST_STOP:  if (centre_c)                       state_d = ST_IDLE;
            default:                                      state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            shreg_q   <= '0;
            rx_prev_q <= 1'b1;
            done_q    <= 1'b0;
            stop_q    <= 1'b1;
            cfg_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (tick_i) rx_prev_q <= rx_i;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                end
                ST_START: begin
                    if (mid_c) begin
                        cnt_q <= '0;
                        if (!rx_i) begin
                            idx_q          <= '0;
                            shreg_q        <= '0;
                            cfg_q.nine     <= (mode_i == MODE_UART9);
                            cfg_q.par_en   <= par_en_i && (mode_i == MODE_UART8);
                            cfg_q.par_even <= par_even_i;
                            cfg_q.wake     <= wake_en_i;
                        end
                    end else if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (centre_c) begin
                        cnt_q          <= '0;
                        shreg_q[idx_q] <= rx_i;
                        idx_q          <= idx_q + 1'b1;
                    end else if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (centre_c) begin
                        cnt_q  <= '0;
                        stop_q <= rx_i;
                        done_q <= 1'b1;
                    end else if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign done_o = done_q;
    assign bits_o = shreg_q;
    assign stop_o = stop_q;
    assign cfg_o  = cfg_q;

endmodule

// File: rtl/mdrop_rx_result.sv
module mdrop_rx_result
    import mdrop_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DW:0]       bits_i,
    input  logic              stop_i,
    input  frame_cfg_t        cfg_i,
    input  logic              ack_i,
    output logic [DW-1:0]     data_o,
    output logic              rb8_o,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);

    logic [DW-1:0] data_q;
    logic          rb8_q;
    logic          valid_q;
    logic          ferr_q;
    logic          perr_q;
    logic          ovr_q;
    logic          irq_q;

    logic          blocked_c;
    logic          accept_c;
    logic          perr_c;

    // wake-up filter: in 9-bit mode only address frames pass
    assign blocked_c = cfg_i.nine && cfg_i.wake && !bits_i[DW];
    assign accept_c  = done_i && !blocked_c;
    assign perr_c    = cfg_i.par_en && ((^bits_i) ^ !cfg_i.par_even);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            rb8_q   <= 1'b0;
            valid_q <= 1'b0;
            ferr_q  <= 1'b0;
            perr_q  <= 1'b0;
            ovr_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= accept_c;
            if (accept_c) begin
                data_q  <= bits_i[DW-1:0];
                rb8_q   <= cfg_i.nine && bits_i[DW];
                valid_q <= 1'b1;
                ferr_q  <= !stop_i;
                perr_q  <= perr_c;
                ovr_q   <= valid_q && !ack_i;
            end else if (ack_i) begin
                valid_q <= 1'b0;
                ferr_q  <= 1'b0;
                perr_q  <= 1'b0;
                ovr_q   <= 1'b0;
            end
        end
    end

    always_comb begin
        status_o             = '0;
        status_o[STAT_VALID] = valid_q;
        status_o[STAT_FERR]  = ferr_q;
        status_o[STAT_PERR]  = perr_q;
        status_o[STAT_OVR]   = ovr_q;
    end

    assign data_o = data_q;
    assign rb8_o  = rb8_q;
    assign irq_o  = irq_q;

endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
    import mdrop_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd_i,
    input  logic          tick16_i,
    input  logic [1:0]    mode_i,
    input  logic          par_en_i,
    input  logic          par_even_i,
    input  logic          wake_en_i,
    input  logic          ack_i,
    output logic [DW-1:0] data_o,
    output logic          rb8_o,
    output logic [7:0]    status_o,
    output logic          irq_o
);

    logic       rx_s;
    logic       frm_done;
    logic [DW:0] frm_bits;
    logic       frm_stop;
    frame_cfg_t frm_cfg;

    mdrop_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_i  (rxd_i),
        .rx_o  (rx_s)
    );

    mdrop_rx_fsm #(.OSR(OSR), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick16_i),
        .rx_i       (rx_s),
        .mode_i     (mode_i),
        .par_en_i   (par_en_i),
        .par_even_i (par_even_i),
        .wake_en_i  (wake_en_i),
        .done_o     (frm_done),
        .bits_o     (frm_bits),
        .stop_o     (frm_stop),
        .cfg_o      (frm_cfg)
    );

    mdrop_rx_result #(.DW(DW)) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (frm_done),
        .bits_i   (frm_bits),
        .stop_i   (frm_stop),
        .cfg_i    (frm_cfg),
        .ack_i    (ack_i),
        .data_o   (data_o),
        .rb8_o    (rb8_o),
        .status_o (status_o),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/mdrop_rx_chk.sv
module mdrop_rx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack_i,
    input logic          irq_o,
    input logic          rb8_o,
    input logic [7:0]    status_o,
    input logic [DW-1:0] data_o,
    input logic          frame_done,
    input logic          cfg_nine,
    input logic          cfg_wake
);

    // R12: interrupt lasts one cycle
    a_r12_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R12: interrupt follows a completed frame from the bit engine
    a_r12_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(frame_done));

    // R1: an interrupting frame is marked valid
    a_r1_valid_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> status_o[0]);

    // R1: ninth bit is zero in 8-bit framing
    a_r1_rb8_zero_8bit: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !cfg_nine) |-> !rb8_o);

    // R4: no parity error in 9-bit framing
    a_r4_no_parity_9bit: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && cfg_nine) |-> !status_o[3]);

    // R5: with wake-up, only address frames interrupt
    a_r5_wake_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && cfg_nine && cfg_wake) |-> rb8_o);

    // R9: acknowledge without a new frame clears flags
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !frame_done) |=> (status_o[4:0] == 5'b0));

    // R9: without a frame or acknowledge, results hold
    a_r9_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done && !ack_i) |=> ($stable(data_o) && $stable(status_o)));

endmodule

bind mdrop_rx mdrop_rx_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_i      (ack_i),
    .irq_o      (irq_o),
    .rb8_o      (rb8_o),
    .status_o   (status_o),
    .data_o     (data_o),
    .frame_done (frm_done),
    .cfg_nine   (frm_cfg.nine),
    .cfg_wake   (frm_cfg.wake)
);

// File: tb/mdrop_rx_tb.sv
module mdrop_rx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLKS   = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd_i = 1'b1;
    logic       tick16_i = 1'b0;
    logic [1:0] mode_i = 2'b10;
    logic       par_en_i = 1'b0;
    logic       par_even_i = 1'b0;
    logic       wake_en_i = 1'b0;
    logic       ack_i = 1'b0;
    logic [7:0] data_o;
    logic       rb8_o;
    logic [7:0] status_o;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;
    bit hold_ack = 0;
    bit man_ack  = 0;
    bit finished = 0;
    logic [16:0] exp_q[$];

    mdrop_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd_i      (rxd_i),
        .tick16_i   (tick16_i),
        .mode_i     (mode_i),
        .par_en_i   (par_en_i),
        .par_even_i (par_even_i),
        .wake_en_i  (wake_en_i),
        .ack_i      (ack_i),
        .data_o     (data_o),
        .rb8_o      (rb8_o),
        .status_o   (status_o),
        .irq_o      (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // oversampling tick source
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            tick16_i = (div == 0);
            div = (div + 1) % TICK_DIV;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_item(input logic [7:0] d, input logic r8, input logic [7:0] st);
        exp_q.push_back({d, r8, st});
    endtask

    task automatic send_frame(input logic [8:0] payload, input int nbits, input logic stop_bit);
        @(negedge clk);
        rxd_i = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            rxd_i = payload[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        rxd_i = stop_bit;
        repeat (BIT_CLKS) @(negedge clk);
        rxd_i = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
    endtask

    task automatic check_drained(input string req);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // monitor and scoreboard
    initial begin
        bit prev_irq = 0;
        forever begin
            @(negedge clk);
            ack_i = 1'b0;
            if (man_ack) begin
                ack_i = 1'b1;
                man_ack = 0;
            end
            if (irq_o && prev_irq)
                check(0, "R12 irq width", 1, 0);
            if (irq_o) begin
                if (exp_q.size() == 0) begin
                    check(0, "R5/R11 unexpected irq", {data_o, rb8_o, status_o}, 0);
                end else begin
                    logic [16:0] e;
                    e = exp_q.pop_front();
                    check({data_o, rb8_o, status_o} == e, "R12 result at irq",
                          {data_o, rb8_o, status_o}, e);
                end
                if (!hold_ack) ack_i = 1'b1;
            end
            prev_irq = irq_o;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R13 reset state
        check(data_o == 8'h00 && rb8_o == 1'b0 && status_o == 8'h00 && irq_o == 1'b0,
              "R13 reset", {data_o, rb8_o, status_o, irq_o}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R1, R3: 8-bit mode without parity
        mode_i = 2'b10; par_en_i = 0;
        expect_item(8'hA5, 0, 8'h01); send_frame({1'b0, 8'hA5}, 8, 1'b1);
        expect_item(8'h3C, 0, 8'h01); send_frame({1'b0, 8'h3C}, 8, 1'b1);
        expect_item(8'h80, 0, 8'h01); send_frame({1'b0, 8'h80}, 8, 1'b1);
        check_drained("R1 8-bit frames");
        check(status_o == 8'h00, "R9 ack clears", status_o, 8'h00);
        check(data_o == 8'h80, "R9 data kept after ack", data_o, 8'h80);

        // R2: even parity, good then bad
        par_en_i = 1; par_even_i = 1;
        expect_item(8'h0F, 0, 8'h01); send_frame({1'b0, 8'h0F}, 9, 1'b1);
        expect_item(8'h07, 0, 8'h09); send_frame({1'b0, 8'h07}, 9, 1'b1);
        // R2: odd parity, good then bad
        par_even_i = 0;
        expect_item(8'h07, 0, 8'h01); send_frame({1'b0, 8'h07}, 9, 1'b1);
        expect_item(8'h00, 0, 8'h09); send_frame({1'b0, 8'h00}, 9, 1'b1);
        expect_item(8'h00, 0, 8'h01); send_frame({1'b1, 8'h00}, 9, 1'b1);
        check_drained("R2 parity frames");

        // R4, R6: 9-bit mode, wake-up off, parity enable ignored
        mode_i = 2'b11; par_en_i = 1; par_even_i = 1; wake_en_i = 0;
        expect_item(8'h55, 1, 8'h01); send_frame({1'b1, 8'h55}, 9, 1'b1);
        expect_item(8'hAA, 0, 8'h01); send_frame({1'b0, 8'hAA}, 9, 1'b1);
        expect_item(8'h01, 0, 8'h01); send_frame({1'b0, 8'h01}, 9, 1'b1);
        check_drained("R6 all frames interrupt");

        // R5: wake-up on, data frame dropped
        wake_en_i = 1;
        send_frame({1'b0, 8'h11}, 9, 1'b1);
        check_drained("R5 data frame no irq");
        check(data_o == 8'h01 && status_o == 8'h00 && rb8_o == 1'b0,
              "R5 data frame not loaded", {data_o, rb8_o, status_o}, {8'h01, 1'b0, 8'h00});
        expect_item(8'h42, 1, 8'h01); send_frame({1'b1, 8'h42}, 9, 1'b1);
        check_drained("R5 address frame irq");
        wake_en_i = 0;

        // R7: framing error
        mode_i = 2'b10; par_en_i = 0;
        expect_item(8'h99, 0, 8'h05); send_frame({1'b0, 8'h99}, 8, 1'b0);
        expect_item(8'h66, 0, 8'h01); send_frame({1'b0, 8'h66}, 8, 1'b1);
        check_drained("R7 framing");

        // R8: overrun
        hold_ack = 1;
        expect_item(8'h12, 0, 8'h01); send_frame({1'b0, 8'h12}, 8, 1'b1);
        expect_item(8'h34, 0, 8'h11); send_frame({1'b0, 8'h34}, 8, 1'b1);
        check_drained("R8 overrun");
        man_ack = 1;
        repeat (4) @(negedge clk);
        check(status_o == 8'h00 && data_o == 8'h34, "R9 manual ack",
              {data_o, status_o}, {8'h34, 8'h00});
        hold_ack = 0;

        // R10: short glitch is not a start bit
        @(negedge clk); rxd_i = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rxd_i = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        check_drained("R10 glitch rejected");
        check(status_o == 8'h00, "R10 glitch status", status_o, 8'h00);

        // R11: disabled modes
        mode_i = 2'b00;
        send_frame({1'b0, 8'h77}, 8, 1'b1);
        mode_i = 2'b01;
        send_frame({1'b0, 8'h78}, 8, 1'b1);
        check_drained("R11 disabled modes");
        check(status_o == 8'h00 && data_o == 8'h34, "R11 outputs unchanged",
              {data_o, status_o}, {8'h34, 8'h00});

        // R10: receiver recovers after disabled mode
        mode_i = 2'b10;
        expect_item(8'hC3, 0, 8'h01); send_frame({1'b0, 8'hC3}, 8, 1'b1);
        check_drained("R10 normal start");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule